// File: doc/BRIEF.md
# DMA Channel Transfer Sequencer

This block is a single channel of a peripheral DMA engine. It moves a block of items between a dual-port buffer RAM and one peripheral data register, in either direction. A small write-only register port sets up the channel: two buffer start addresses, a peripheral register address, a transfer count, mode bits and a request-source select. Once the channel is enabled, a trigger from the selected request line or from a software force write makes a transfer pending. The channel then raises a request toward an external arbiter. Each cycle in which the arbiter grants that request carries exactly one RAM access and one peripheral access, both driven combinationally in the grant cycle.

The channel keeps the RAM address and the number of transfers done so far. The RAM address can advance by the item size after each transfer, stay fixed, or come from an offset that the peripheral supplies. At the end of a block the channel can switch between its two buffers (ping-pong) and can either switch itself off (one-shot) or reload and keep running (auto-repeat). It raises sticky interrupt flags at the end of the block, or at its midpoint when half mode is selected. Software clears these flags by writing ones.

Top module: `dma_chan_seq`

Register map (a write takes effect at the clock edge where `regWe` is high). Register index 0 is the control register, with these fields:
- bit 0: enable
- bit 1: direction (1 = RAM to peripheral, 0 = peripheral to RAM)
- bit 2: byte size (1 = byte, 0 = word)
- bit 3: fixed address (no post-increment)
- bit 4: peripheral-indirect addressing
- bit 5: half mode
- bit 6: auto-repeat
- bit 7: ping-pong
- bits 10:8: request-source select

The other registers are:
- 1: start address A
- 2: start address B
- 3: peripheral address
- 4: count (number of transfers minus one)
- 5: force (bit 0 = 1 makes a transfer pending)
- 6: status, write one to clear (bit 0 half flag, bit 1 done flag, bit 2 collision)

## Requirements
- R1: After reset, `dmaReq`, `ramEn`, `perEn`, `irqHalf`, `irqDone`, `collision`, `activeBuf` and `chanEn` are all 0.
- R2: `dmaReq` is 1 only while the channel is enabled with a transfer pending. A cycle with `dmaReq` and `grant` both high gives `ramEn`=`perEn`=1, `perAddr` equal to the peripheral address register, and the write strobe on the destination side only: `perWe` when the direction bit is 1, `ramWe` when it is 0.
- R3: With post-increment, the first transfer after a control write uses start address A, and each later transfer uses an address 1 higher (byte size) or 2 higher (word size) than the one before.
- R4: With the fixed-address bit set, every transfer in the block uses the same start address.
- R5: In peripheral-indirect mode, `ramAddr` equals the active start address plus `perOffset`.
- R6: A trigger is a 1 on `trigVec[select]` or a force write with bit 0 set. Triggers on other lines, and triggers while the channel is disabled, leave `dmaReq` at 0.
- R7: When half mode is off, `irqDone` sets after transfer number count+1 of a block, and not before.
- R8: When half mode is on, `irqHalf` sets after transfer number floor((count+1)/2), and `irqDone` stays 0 for that block.
- R9: In one-shot mode (auto-repeat bit 0), `chanEn` drops after the last transfer of the block. In auto-repeat mode the channel stays enabled and the next block starts again from the first address of the active buffer.
- R10: In ping-pong mode, `activeBuf` toggles at each block end, and the next block starts at start address B when `activeBuf` is 1 and at start address A when it is 0. A control write sets `activeBuf` back to 0.
- R11: A trigger that arrives while a transfer is still pending and is not granted in that cycle sets `collision`.
- R12: The flags are sticky. Writing a 1 to a flag's status bit clears that flag, and writing a 0 leaves it unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| regWe | input | 1 | Register write strobe |
| regAddr | input | 3 | Register index |
| regWdata | input | 16 | Register write data |
| trigVec | input | NSRC (8) | Request lines from interrupt sources |
| grant | input | 1 | Grant from the external arbiter |
| perOffset | input | ADDR_W (12) | RAM offset supplied by the peripheral |
| dmaReq | output | 1 | Request to the arbiter |
| ramEn | output | 1 | RAM access strobe |
| ramWe | output | 1 | RAM write strobe |
| ramByte | output | 1 | Access is a byte |
| ramAddr | output | ADDR_W (12) | RAM address |
| perEn | output | 1 | Peripheral access strobe |
| perWe | output | 1 | Peripheral write strobe |
| perAddr | output | PER_W (8) | Peripheral register address |
| irqHalf | output | 1 | Sticky half-block flag |
| irqDone | output | 1 | Sticky block-complete flag |
| collision | output | 1 | Sticky trigger-collision flag |
| activeBuf | output | 1 | Active buffer (0 = A, 1 = B) |
| chanEn | output | 1 | Channel enable state |

## Verification
The assertions check the following on every cycle:
- the address steps by the item size or holds, depending on the mode;
- the transfer counter never passes the programmed count;
- a one-shot block end always turns the channel off;
- a ping-pong block end always flips the active buffer;
- a collision appears only when a transfer was already pending.

Some behaviour only the bench scenarios can show: the exact transfer that raises the half or done flag, the absolute address sequence across byte and word sweeps and across buffer swaps, and the lines that select or ignore a trigger. The write-one-to-clear behaviour of the status register is also shown only by the bench.

// File: rtl/dma_chan_pkg.sv
package dma_chan_pkg;

  localparam logic [2:0] REG_CTRL   = 3'd0;
  localparam logic [2:0] REG_STARTA = 3'd1;
  localparam logic [2:0] REG_STARTB = 3'd2;
  localparam logic [2:0] REG_PER    = 3'd3;
  localparam logic [2:0] REG_COUNT  = 3'd4;
  localparam logic [2:0] REG_FORCE  = 3'd5;
  localparam logic [2:0] REG_STATUS = 3'd6;

  typedef struct packed {
    logic en;
    logic dir;       // 1: RAM to peripheral
    logic byteMode;
    logic noInc;
    logic perInd;
    logic halfMode;
    logic autoRep;
    logic pingPong;
  } chanCfg_t;

  typedef struct packed {
    logic load;      // control write: restart at buffer A
    logic xfer;      // one granted transfer this cycle
    logic blockEnd;  // the transfer is the last of the block
    logic wrA;
    logic wrB;
    logic wrPer;
  } dpStrobe_t;

endpackage

// File: rtl/dma_chan_ctrl.sv
module dma_chan_ctrl
  import dma_chan_pkg::*;
#(
  parameter int CNT_W  = 8,
  parameter int NSRC   = 8,
  parameter int DATA_W = 16,
  localparam int SEL_W = (NSRC > 1) ? $clog2(NSRC) : 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWe,
  input  logic [2:0]        regAddr,
  input  logic [DATA_W-1:0] regWdata,
  input  logic [NSRC-1:0]   trigVec,
  input  logic              grant,
  output chanCfg_t          cfg,
  output dpStrobe_t         stb,
  output logic              dmaReq,
  output logic              irqHalf,
  output logic              irqDone,
  output logic              collision
);

  logic [SEL_W-1:0] selReg;
  logic [CNT_W-1:0] countReg;
  logic [CNT_W-1:0] xferCnt;
  logic             pending;

  logic ctrlWr, countWr, forceWr, statWr;
  logic newTrig, xfer, lastXfer, hitHalf, collide;
  logic [CNT_W:0] halfPt;
  logic [CNT_W:0] doneNext;

  always_comb begin
    ctrlWr   = regWe && (regAddr == REG_CTRL);
    countWr  = regWe && (regAddr == REG_COUNT);
    forceWr  = regWe && (regAddr == REG_FORCE) && regWdata[0];
    statWr   = regWe && (regAddr == REG_STATUS);
    newTrig  = cfg.en && (trigVec[selReg] || forceWr);
    dmaReq   = cfg.en && pending;
    xfer     = dmaReq && grant;
    lastXfer = xfer && (xferCnt == countReg);
    halfPt   = ({1'b0, countReg} + 1'b1) >> 1;
    doneNext = {1'b0, xferCnt} + 1'b1;
    hitHalf  = xfer && cfg.halfMode && (doneNext == halfPt);
    collide  = newTrig && pending && !xfer && !ctrlWr;
  end

  always_comb begin
    stb.load     = ctrlWr;
    stb.xfer     = xfer;
    stb.blockEnd = lastXfer && !ctrlWr;
    stb.wrA      = regWe && (regAddr == REG_STARTA);
    stb.wrB      = regWe && (regAddr == REG_STARTB);
    stb.wrPer    = regWe && (regAddr == REG_PER);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cfg      <= '0;
      selReg   <= '0;
      countReg <= '0;
      xferCnt  <= '0;
      pending  <= 1'b0;
    end else if (ctrlWr) begin
      cfg.en       <= regWdata[0];
      cfg.dir      <= regWdata[1];
      cfg.byteMode <= regWdata[2];
      cfg.noInc    <= regWdata[3];
      cfg.perInd   <= regWdata[4];
      cfg.halfMode <= regWdata[5];
      cfg.autoRep  <= regWdata[6];
      cfg.pingPong <= regWdata[7];
      selReg       <= regWdata[8 +: SEL_W];
      xferCnt      <= '0;
      pending      <= 1'b0;
    end else begin
      pending <= (pending && !xfer) || newTrig;
      if (countWr) begin
        countReg <= regWdata[CNT_W-1:0];
        xferCnt  <= '0;
      end else if (xfer) begin
        xferCnt <= lastXfer ? '0 : xferCnt + 1'b1;
      end
      if (lastXfer && !cfg.autoRep) cfg.en <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      irqHalf   <= 1'b0;
      irqDone   <= 1'b0;
      collision <= 1'b0;
    end else begin
      irqHalf   <= (irqHalf && !(statWr && regWdata[0])) || hitHalf;
      irqDone   <= (irqDone && !(statWr && regWdata[1])) ||
                   (lastXfer && !cfg.halfMode);
      collision <= (collision && !(statWr && regWdata[2])) || collide;
    end
  end

  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rstN)
    xferCnt <= countReg);  // R7

  AST_ONESHOT_OFF: assert property (@(posedge clk) disable iff (!rstN)
    (stb.blockEnd && !cfg.autoRep) |=> !cfg.en);  // R9

  AST_COLL_PENDING: assert property (@(posedge clk) disable iff (!rstN)
    $rose(collision) |-> $past(pending));  // R11

endmodule

// File: rtl/dma_chan_dp.sv
module dma_chan_dp
  import dma_chan_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int PER_W  = 8,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  chanCfg_t          cfg,
  input  dpStrobe_t         stb,
  input  logic [DATA_W-1:0] regWdata,
  input  logic [ADDR_W-1:0] perOffset,
  output logic [ADDR_W-1:0] ramAddr,
  output logic [PER_W-1:0]  perAddr,
  output logic              activeBuf
);

  logic [ADDR_W-1:0] startA, startB, curAddr, baseAddr, stepSize;
  logic              nextBuf;

  always_comb begin
    baseAddr = activeBuf ? startB : startA;
    stepSize = cfg.byteMode ? ADDR_W'(1) : ADDR_W'(2);
    nextBuf  = cfg.pingPong ? !activeBuf : activeBuf;
    ramAddr  = cfg.perInd ? baseAddr + perOffset : curAddr;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      startA  <= '0;
      startB  <= '0;
      perAddr <= '0;
    end else begin
      if (stb.wrA)   startA  <= regWdata[ADDR_W-1:0];
      if (stb.wrB)   startB  <= regWdata[ADDR_W-1:0];
      if (stb.wrPer) perAddr <= regWdata[PER_W-1:0];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      curAddr   <= '0;
      activeBuf <= 1'b0;
    end else if (stb.load) begin
      curAddr   <= startA;
      activeBuf <= 1'b0;
    end else if (stb.blockEnd) begin
      curAddr   <= nextBuf ? startB : startA;
      activeBuf <= nextBuf;
    end else if (stb.xfer && !cfg.noInc && !cfg.perInd) begin
      curAddr <= curAddr + stepSize;
    end
  end

  AST_ADDR_STEP: assert property (@(posedge clk) disable iff (!rstN)
    (stb.xfer && !stb.blockEnd && !stb.load && !cfg.noInc && !cfg.perInd)
      |=> (curAddr == $past(curAddr) + $past(stepSize)));  // R3

  AST_ADDR_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (stb.xfer && !stb.blockEnd && !stb.load && cfg.noInc) |=> $stable(curAddr));  // R4

  AST_PP_SWAP: assert property (@(posedge clk) disable iff (!rstN)
    (stb.blockEnd && cfg.pingPong) |=> (activeBuf != $past(activeBuf)));  // R10

endmodule

// File: rtl/dma_chan_seq.sv
module dma_chan_seq
  import dma_chan_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int PER_W  = 8,
  parameter int CNT_W  = 8,
  parameter int NSRC   = 8,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWe,
  input  logic [2:0]        regAddr,
  input  logic [DATA_W-1:0] regWdata,
  input  logic [NSRC-1:0]   trigVec,
  input  logic              grant,
  input  logic [ADDR_W-1:0] perOffset,
  output logic              dmaReq,
  output logic              ramEn,
  output logic              ramWe,
  output logic              ramByte,
  output logic [ADDR_W-1:0] ramAddr,
  output logic              perEn,
  output logic              perWe,
  output logic [PER_W-1:0]  perAddr,
  output logic              irqHalf,
  output logic              irqDone,
  output logic              collision,
  output logic              activeBuf,
  output logic              chanEn
);

  chanCfg_t  cfg;
  dpStrobe_t stb;

  dma_chan_ctrl #(.CNT_W(CNT_W), .NSRC(NSRC), .DATA_W(DATA_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .regWe(regWe), .regAddr(regAddr),
    .regWdata(regWdata), .trigVec(trigVec), .grant(grant),
    .cfg(cfg), .stb(stb), .dmaReq(dmaReq), .irqHalf(irqHalf),
    .irqDone(irqDone), .collision(collision)
  );

  dma_chan_dp #(.ADDR_W(ADDR_W), .PER_W(PER_W), .DATA_W(DATA_W)) u_dp (
    .clk(clk), .rstN(rstN), .cfg(cfg), .stb(stb), .regWdata(regWdata),
    .perOffset(perOffset), .ramAddr(ramAddr), .perAddr(perAddr),
    .activeBuf(activeBuf)
  );

  always_comb begin
    ramEn   = stb.xfer;
    perEn   = stb.xfer;
    ramWe   = stb.xfer && !cfg.dir;
    perWe   = stb.xfer && cfg.dir;
    ramByte = cfg.byteMode;
    chanEn  = cfg.en;
  end

endmodule

// File: tb/tb_dma_chan_seq.sv
module tb_dma_chan_seq;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        regWe = 1'b0;
  logic [2:0]  regAddr = '0;
  logic [15:0] regWdata = '0;
  logic [7:0]  trigVec = '0;
  logic        grant = 1'b0;
  logic [11:0] perOffset = '0;
  logic        dmaReq, ramEn, ramWe, ramByte, perEn, perWe;
  logic [11:0] ramAddr;
  logic [7:0]  perAddr;
  logic        irqHalf, irqDone, collision, activeBuf, chanEn;

  int checks = 0;
  int fails = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dma_chan_seq dut (.*);

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic wr(input logic [2:0] a, input logic [15:0] d);
    regWe = 1'b1; regAddr = a; regWdata = d;
    tick();
    regWe = 1'b0;
  endtask

  function automatic logic [15:0] ctl(input bit en, input bit dir, input bit by,
      input bit fix, input bit pind, input bit half, input bit rep, input bit pp,
      input int sel);
    return {5'd0, 3'(sel), pp, rep, half, pind, fix, by, dir, en};
  endfunction

  task automatic trig(input int s);
    trigVec[s] = 1'b1;
    tick();
    trigVec = '0;
  endtask

  // one granted transfer: check strobes and address in the grant cycle
  task automatic xfer(input string req, input logic [11:0] expAddr, input bit dir);
    #1;
    chk("R2 req", dmaReq, 1);
    grant = 1'b1;
    #1;
    chk("R2 ramEn", ramEn, 1);
    chk("R2 perEn", perEn, 1);
    chk("R2 ramWe", ramWe, !dir);
    chk("R2 perWe", perWe, dir);
    chk(req, ramAddr, expAddr);
    tick();
    grant = 1'b0;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    fails++; checks++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    logic [11:0] base;
    int step;
    int half;
    repeat (2) tick();
    // R1 reset state
    chk("R1 dmaReq", dmaReq, 0); chk("R1 ramEn", ramEn, 0); chk("R1 perEn", perEn, 0);
    chk("R1 irqHalf", irqHalf, 0); chk("R1 irqDone", irqDone, 0);
    chk("R1 collision", collision, 0); chk("R1 activeBuf", activeBuf, 0);
    chk("R1 chanEn", chanEn, 0);
    rstN = 1'b1;
    tick();
    wr(3'd3, 16'h5A);

    // R3/R7/R9: sweep sizes and counts, one-shot, post-increment
    for (int by = 0; by < 2; by++) begin
      for (int cnt = 0; cnt < 5; cnt++) begin
        base = 12'(16'h100 + cnt * 16'h20 + by);
        step = by ? 1 : 2;
        wr(3'd1, 16'(base));
        wr(3'd4, 16'(cnt));
        wr(3'd0, ctl(1, 0, by[0], 0, 0, 0, 0, 0, 2));
        for (int i = 0; i <= cnt; i++) begin
          chk("R7 not yet done", irqDone, 0);
          trig(2);
          xfer("R3 address", 12'(base + i * step), 0);
        end
        chk("R2 perAddr", perAddr, 8'h5A);
        chk("R7 done", irqDone, 1);
        chk("R9 one-shot off", chanEn, 0);
        wr(3'd6, 16'h0001);
        chk("R12 zero bit keeps flag", irqDone, 1);
        wr(3'd6, 16'h0002);
        chk("R12 clear done", irqDone, 0);
      end
    end

    // R4 fixed address
    wr(3'd1, 16'h240); wr(3'd4, 16'd2);
    wr(3'd0, ctl(1, 0, 0, 1, 0, 0, 0, 0, 2));
    for (int i = 0; i < 3; i++) begin trig(2); xfer("R4 fixed", 12'h240, 0); end
    wr(3'd6, 16'h0007);

    // R5 peripheral indirect
    wr(3'd1, 16'h300); wr(3'd4, 16'd3);
    wr(3'd0, ctl(1, 0, 0, 0, 1, 0, 0, 0, 2));
    for (int i = 0; i < 4; i++) begin
      perOffset = 12'(i * 7 + 1);
      trig(2);
      xfer("R5 indirect", 12'(16'h300 + i * 7 + 1), 0);
    end
    perOffset = '0;
    wr(3'd6, 16'h0007);

    // R8 half mode, several counts
    for (int cnt = 1; cnt < 6; cnt++) begin
      half = (cnt + 1) / 2;
      wr(3'd1, 16'h400); wr(3'd4, 16'(cnt));
      wr(3'd0, ctl(1, 0, 0, 0, 0, 1, 0, 0, 2));
      for (int i = 1; i <= cnt + 1; i++) begin
        trig(2);
        xfer("R8 addr", 12'(16'h400 + (i - 1) * 2), 0);
        chk("R8 half flag", irqHalf, (i >= half) ? 1 : 0);
      end
      chk("R8 no done", irqDone, 0);
      wr(3'd6, 16'h0001);
      chk("R12 clear half", irqHalf, 0);
    end

    // R9/R10 auto-repeat with ping-pong
    wr(3'd1, 16'h100); wr(3'd2, 16'h200); wr(3'd4, 16'd1);
    wr(3'd0, ctl(1, 0, 0, 0, 0, 0, 1, 1, 2));
    for (int blk = 0; blk < 4; blk++) begin
      base = blk[0] ? 12'h200 : 12'h100;
      chk("R10 activeBuf", activeBuf, blk[0]);
      for (int i = 0; i < 2; i++) begin trig(2); xfer("R10 buffer addr", 12'(base + i * 2), 0); end
      chk("R9 still enabled", chanEn, 1);
    end
    wr(3'd0, ctl(1, 0, 0, 0, 0, 0, 1, 1, 2));
    chk("R10 control write resets buffer", activeBuf, 0);

    // R9 auto-repeat without ping-pong restarts at A
    wr(3'd0, ctl(1, 0, 0, 0, 0, 0, 1, 0, 2));
    for (int blk = 0; blk < 2; blk++)
      for (int i = 0; i < 2; i++) begin trig(2); xfer("R9 reload addr", 12'(16'h100 + i * 2), 0); end
    chk("R9 same buffer", activeBuf, 0);
    wr(3'd6, 16'h0007);

    // R6/R2 force trigger, RAM to peripheral
    wr(3'd4, 16'd0);
    wr(3'd0, ctl(1, 1, 0, 0, 0, 0, 0, 0, 5));
    #1 chk("R6 idle before force", dmaReq, 0);
    trig(2);
    #1 chk("R6 other line ignored", dmaReq, 0);
    wr(3'd5, 16'h0001);
    xfer("R6 force addr", 12'h100, 1);
    chk("R2 perAddr dir1", perAddr, 8'h5A);
    wr(3'd6, 16'h0007);

    // R6 disabled channel ignores triggers
    wr(3'd0, ctl(0, 0, 0, 0, 0, 0, 0, 0, 2));
    trig(2);
    wr(3'd5, 16'h0001);
    #1 chk("R6 disabled ignore", dmaReq, 0);
    chk("R11 no collision when disabled", collision, 0);

    // R11 collision
    wr(3'd4, 16'd3);
    wr(3'd0, ctl(1, 0, 0, 0, 0, 0, 0, 0, 2));
    trig(2);
    chk("R11 single trigger", collision, 0);
    trig(2);
    chk("R11 collision", collision, 1);
    xfer("R11 addr", 12'h100, 0);
    wr(3'd6, 16'h0004);
    chk("R12 clear collision", collision, 0);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule